// File: doc/BRIEF.md
# Pulse-Selected Successive-Approximation Converter Control

This block is the digital half of a small serial-output analog-to-digital converter. A single start line does three jobs. Its level and edges move the converter between shutdown, track and conversion. The pattern of pulses on it chooses between a primary input (or unipolar coding) and an alternate input (or bipolar coding). A readout left unfinished also changes that choice for the next conversion. The comparator decision and a conversion-clock enable arrive as plain inputs. The block runs a 12-step successive-approximation search, drives the trial word to the external DAC and shifts the result out most significant bit first, one bit on each falling edge of an external serial clock.

Start, serial clock, tick and comparator inputs are sampled on the rising edge of `clk`. An edge on start or on the serial clock is detected by comparing the sample with the one taken a cycle earlier. The single data pin reports where the converter is through its levels. It is released while idle or tracking, held low while converting, and then carries the result until the last bit has been shifted out.

Top module: `pulse_sar_adc`

## Requirements
- R1: After reset `dout_oe_o`, `track_o`, `busy_o`, `alt_sel_o` and `dac_code_o` are all 0.
- R2: A rising start edge seen while idle sets `track_o` in the following cycle. A falling edge after at least `ACQ_CYC` high samples clears `track_o`, sets `busy_o`, drives `dout_oe_o`=1 and `dout_o`=0, and starts the conversion.
- R3: A start high lasting at least `PULSE_MIN` but fewer than `ACQ_CYC` samples, then a low of at least `PULSE_MIN` samples, then a new high marks the alternate selection. The conversion it leads to reports `alt_sel_o`=1. A single high long enough to acquire reports `alt_sel_o`=0. `alt_sel_o` holds its value for the whole conversion and readout.
- R4: A start high shorter than `PULSE_MIN` samples returns the block to idle with no conversion. A low shorter than `PULSE_MIN` samples between two highs cancels the alternate selection.
- R5: Each cycle with `conv_tick_i`=1 during conversion decides one bit, from bit 11 down to bit 0, taking the bit as `cmp_hi_i`. `dac_code_o` shows the bits decided so far with the bit under trial set, and it is 0 outside conversion. A tick in the cycle that starts the conversion is not used.
- R6: The twelfth tick ends the conversion: `busy_o` drops and `dout_o` presents bit 11 of the result with `dout_oe_o`=1.
- R7: With `alt_sel_o`=0 the result equals the decided word (straight binary). With `alt_sel_o`=1 the result is the decided word with bit 11 inverted (two's complement).
- R8: Each serial-clock falling edge during readout moves `dout_o` to the next lower bit. The twelfth falling edge sets `dout_oe_o` to 0 and the block returns to idle shutdown.
- R9: A start rising edge during conversion or before twelve bits have been read aborts at once: `dout_oe_o` goes to 0 and tracking restarts. The next conversion then uses the alternate selection, whatever pattern is on start. The forced selection applies to that one conversion only.
- R10: Serial-clock edges outside readout have no effect: while idle `dout_oe_o` stays 0, and while converting `dout_o` stays 0.
- R11: `dout_oe_o` is 0 while tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start line: wake, track, select, hold |
| sclk_i | input | 1 | External serial clock |
| conv_tick_i | input | 1 | Conversion-clock enable, one step per pulse |
| cmp_hi_i | input | 1 | Comparator decision for the current trial |
| dout_o | output | 1 | Serial data value |
| dout_oe_o | output | 1 | Serial data drive enable (0 = high impedance) |
| dac_code_o | output | 12 | Trial word for the external DAC |
| track_o | output | 1 | Track phase in progress |
| busy_o | output | 1 | Conversion in progress |
| alt_sel_o | output | 1 | Alternate input or bipolar coding selected |

## Verification
The bench targets how start-line patterns are timed at their edges. A high or low of exactly `PULSE_MIN` samples must count, and one sample fewer must not. A decoder that was off by one would pick the wrong input or start a conversion from a glitch. It also stops readout after a few bits and aborts in the middle of a conversion. A design that forgot the short read, or kept the forced choice too long, would report the wrong `alt_sel_o` and deliver a result with the wrong top bit. Serial-clock activity while idle and during conversion checks that the pin cannot be driven, or its bits consumed, early. All-ones and all-zeros codes in both codings check the MSB inversion at its extremes.

// File: rtl/psar_pkg.sv
package psar_pkg;
  parameter int CODE_W = 12;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_TRACK = 3'd1,
    PH_ARM   = 3'd2,
    PH_CONV  = 3'd3,
    PH_READ  = 3'd4
  } phase_t;

  // Coding step: bipolar results flip the top bit of the search word.
  function automatic logic [CODE_W-1:0] finish_code(input logic [CODE_W-1:0] raw,
                                                    input logic bipolar);
    logic [CODE_W-1:0] flip;
    flip = '0;
    flip[CODE_W-1] = bipolar;
    return raw ^ flip;
  endfunction

  // Keep or drop the bit under trial.
  function automatic logic [CODE_W-1:0] apply_trial(input logic [CODE_W-1:0] decided,
                                                    input logic [CODE_W-1:0] mask,
                                                    input logic keep);
    return keep ? (decided | mask) : decided;
  endfunction
endpackage

// File: rtl/psar_ctrl.sv
module psar_ctrl
  import psar_pkg::*;
#(
  parameter int ACQ_CYC   = 70,
  parameter int PULSE_MIN = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  input  logic   sar_done,
  input  logic   read_done,
  output phase_t phase_o,
  output logic   conv_go,
  output logic   abort,
  output logic   start_rise,
  output logic   sel_alt
);
  localparam int HW = $clog2(ACQ_CYC + 1);
  localparam int LW = $clog2(PULSE_MIN + 1);

  phase_t        phase;
  logic          start_q;
  logic [HW-1:0] hcnt;
  logic [LW-1:0] lcnt;
  logic          pend;
  logic          force_alt;
  logic          start_fall;
  logic          acq_met;
  logic          hi_ok;
  logic          lo_ok;

  assign start_rise = start_i & ~start_q;
  assign start_fall = ~start_i & start_q;
  assign acq_met    = hcnt >= HW'(ACQ_CYC);
  assign hi_ok      = hcnt >= HW'(PULSE_MIN);
  assign lo_ok      = lcnt >= LW'(PULSE_MIN);
  assign conv_go    = (phase == PH_TRACK) && start_fall && acq_met;
  assign abort      = start_rise && ((phase == PH_CONV) || (phase == PH_READ));
  assign phase_o    = phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      start_q   <= 1'b0;
      hcnt      <= '0;
      lcnt      <= '0;
      pend      <= 1'b0;
      force_alt <= 1'b0;
      sel_alt   <= 1'b0;
    end else begin
      start_q <= start_i;
      unique case (phase)
        PH_IDLE: begin
          if (start_rise) begin
            phase <= PH_TRACK;
            hcnt  <= HW'(1);
            pend  <= 1'b0;
          end
        end
        PH_TRACK: begin
          if (start_fall) begin
            if (acq_met) begin
              phase     <= PH_CONV;
              sel_alt   <= pend | force_alt;
              force_alt <= 1'b0;
              pend      <= 1'b0;
            end else if (hi_ok) begin
              phase <= PH_ARM;
              lcnt  <= LW'(1);
            end else begin
              phase <= PH_IDLE;
              pend  <= 1'b0;
            end
          end else if (start_i && !acq_met) begin
            hcnt <= hcnt + HW'(1);
          end
        end
        PH_ARM: begin
          if (start_rise) begin
            phase <= PH_TRACK;
            hcnt  <= HW'(1);
            pend  <= lo_ok;
          end else if (!lo_ok) begin
            lcnt <= lcnt + LW'(1);
          end
        end
        PH_CONV, PH_READ: begin
          if (abort) begin
            phase     <= PH_TRACK;
            hcnt      <= HW'(1);
            pend      <= 1'b0;
            force_alt <= 1'b1;
          end else if (phase == PH_CONV && sar_done) begin
            phase <= PH_READ;
          end else if (phase == PH_READ && read_done) begin
            phase <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/psar_core.sv
module psar_core
  import psar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              abort,
  input  logic              tick,
  input  logic              cmp_hi,
  input  logic              bipolar,
  output logic              done,
  output logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] dac_code
);
  localparam int SW = $clog2(CODE_W);

  logic              active;
  logic [SW-1:0]     step;
  logic [CODE_W-1:0] decided;
  logic [CODE_W-1:0] mask;
  logic [CODE_W-1:0] next_word;

  for (genvar g = 0; g < CODE_W; g++) begin : g_mask
    assign mask[g] = active && (step == SW'(g));
  end

  assign next_word = apply_trial(decided, mask, cmp_hi);
  assign done      = active && tick && (step == '0) && !abort;
  assign code      = finish_code(next_word, bipolar);
  assign dac_code  = active ? (decided | mask) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      step    <= '0;
      decided <= '0;
    end else if (abort) begin
      active <= 1'b0;
    end else if (go) begin
      active  <= 1'b1;
      step    <= SW'(CODE_W - 1);
      decided <= '0;
    end else if (active && tick) begin
      decided <= next_word;
      if (step == '0) active <= 1'b0;
      else            step   <= step - SW'(1);
    end
  end
endmodule

// File: rtl/psar_shift.sv
module psar_shift
  import psar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              abort,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  input  logic              sclk_i,
  output logic              dout,
  output logic              oe,
  output logic              read_done
);
  localparam int CW = $clog2(CODE_W + 1);

  logic              sclk_q;
  logic              sclk_fall;
  logic              reading;
  logic [CODE_W-1:0] sreg;
  logic [CW-1:0]     cnt;

  assign sclk_fall = sclk_q & ~sclk_i;
  assign read_done = reading && sclk_fall && (cnt == CW'(CODE_W - 1));
  assign dout      = reading ? sreg[CODE_W-1] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      reading <= 1'b0;
      oe      <= 1'b0;
      sreg    <= '0;
      cnt     <= '0;
    end else begin
      sclk_q <= sclk_i;
      if (abort) begin
        oe      <= 1'b0;
        reading <= 1'b0;
      end else if (go) begin
        oe      <= 1'b1;
        reading <= 1'b0;
        sreg    <= '0;
      end else if (load) begin
        reading <= 1'b1;
        sreg    <= code;
        cnt     <= '0;
      end else if (reading && sclk_fall) begin
        sreg <= sreg << 1;
        cnt  <= cnt + CW'(1);
        if (read_done) begin
          reading <= 1'b0;
          oe      <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pulse_sar_adc.sv
module pulse_sar_adc
  import psar_pkg::*;
#(
  parameter int ACQ_CYC   = 70,
  parameter int PULSE_MIN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              sclk_i,
  input  logic              conv_tick_i,
  input  logic              cmp_hi_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              track_o,
  output logic              busy_o,
  output logic              alt_sel_o
);
  phase_t            phase;
  logic              conv_go;
  logic              abort_evt;
  logic              start_rise;
  logic              sar_done;
  logic              read_done;
  logic [CODE_W-1:0] result;

  psar_ctrl #(.ACQ_CYC(ACQ_CYC), .PULSE_MIN(PULSE_MIN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sar_done(sar_done),
    .read_done(read_done), .phase_o(phase), .conv_go(conv_go),
    .abort(abort_evt), .start_rise(start_rise), .sel_alt(alt_sel_o)
  );

  psar_core u_core (
    .clk(clk), .rst_n(rst_n), .go(conv_go), .abort(abort_evt),
    .tick(conv_tick_i), .cmp_hi(cmp_hi_i), .bipolar(alt_sel_o),
    .done(sar_done), .code(result), .dac_code(dac_code_o)
  );

  psar_shift u_shift (
    .clk(clk), .rst_n(rst_n), .go(conv_go), .abort(abort_evt),
    .load(sar_done), .code(result), .sclk_i(sclk_i),
    .dout(dout_o), .oe(dout_oe_o), .read_done(read_done)
  );

  assign track_o = (phase == PH_TRACK);
  assign busy_o  = (phase == PH_CONV);
endmodule

// File: rtl/psar_chk.sv
module psar_chk
  import psar_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              conv_tick_i,
  input logic              track_o,
  input logic              busy_o,
  input logic              dout_o,
  input logic              dout_oe_o,
  input logic              alt_sel_o,
  input logic [CODE_W-1:0] dac_code_o,
  input logic              abort_evt
);
  // R11
  track_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    track_o |-> !dout_oe_o);

  // R2
  conv_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (dout_oe_o && !dout_o));

  // R2
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(track_o && busy_o));

  // R5
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && !$past(conv_tick_i)) |-> $stable(dac_code_o));

  // R6
  done_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_o) && !track_o) |-> dout_oe_o);

  // R9
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (track_o && !dout_oe_o));

  // R3
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(alt_sel_o));

  // R10
  conv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (dout_oe_o && !dout_o));
endmodule

bind pulse_sar_adc psar_chk u_chk (
  .clk(clk), .rst_n(rst_n), .conv_tick_i(conv_tick_i), .track_o(track_o),
  .busy_o(busy_o), .dout_o(dout_o), .dout_oe_o(dout_oe_o),
  .alt_sel_o(alt_sel_o), .dac_code_o(dac_code_o), .abort_evt(abort_evt)
);

// File: tb/sim_pulse_sar_adc.sv
module sim_pulse_sar_adc;
  localparam int ACQ  = 70;
  localparam int PMIN = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, sclk = 1'b0, tick = 1'b0, cmp = 1'b0;
  logic dout, oe, trk, busy, sel;
  logic [11:0] dac;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pulse_sar_adc #(.ACQ_CYC(ACQ), .PULSE_MIN(PMIN)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .sclk_i(sclk),
    .conv_tick_i(tick), .cmp_hi_i(cmp), .dout_o(dout), .dout_oe_o(oe),
    .dac_code_o(dac), .track_o(trk), .busy_o(busy), .alt_sel_o(sel)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: mode 0 idle, 1 track, 2 armed low, 3 convert, 4 read.
  int m_mode, m_hi, m_lo, m_step, m_word;
  bit m_pend, m_force, m_sel, m_oe, m_ps, m_pc;
  bit m_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_hi = 0; m_lo = 0; m_step = 0; m_word = 0;
      m_pend = 0; m_force = 0; m_sel = 0; m_oe = 0; m_ps = 0; m_pc = 0;
      m_q.delete();
    end else begin
      bit r, f, sf;
      r  = start && !m_ps;
      f  = !start && m_ps;
      sf = !sclk && m_pc;
      m_ps = start;
      m_pc = sclk;
      if ((m_mode == 3 || m_mode == 4) && r) begin
        m_mode = 1; m_hi = 1; m_pend = 0; m_force = 1; m_oe = 0; m_q.delete();
      end else begin
        case (m_mode)
          0: if (r) begin m_mode = 1; m_hi = 1; m_pend = 0; end
          1: if (f) begin
               if (m_hi >= ACQ) begin
                 m_mode = 3; m_sel = m_pend || m_force; m_force = 0; m_pend = 0;
                 m_step = 11; m_word = 0; m_oe = 1;
               end else if (m_hi >= PMIN) begin
                 m_mode = 2; m_lo = 1;
               end else begin
                 m_mode = 0; m_pend = 0;
               end
             end else if (start) m_hi++;
          2: if (r) begin m_mode = 1; m_hi = 1; m_pend = (m_lo >= PMIN); end
             else m_lo++;
          3: if (tick) begin
               if (cmp) m_word += (1 << m_step);
               if (m_step == 0) begin
                 int fin;
                 fin = m_sel ? (m_word ^ 'h800) : m_word;
                 for (int k = 11; k >= 0; k--) m_q.push_back(fin[k]);
                 m_mode = 4;
               end else m_step--;
             end
          4: if (sf) begin
               void'(m_q.pop_front());
               if (m_q.size() == 0) begin m_oe = 0; m_mode = 0; end
             end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int exp_dac;
      exp_dac = (m_mode == 3) ? (m_word + (1 << m_step)) : 0;
      chk(trk == (m_mode == 1), "R2 track phase", trk, m_mode == 1);
      chk(busy == (m_mode == 3), "R6 busy phase", busy, m_mode == 3);
      chk(oe == m_oe, "R8 drive enable", oe, m_oe);
      if (m_oe) chk(dout == ((m_mode == 4) ? m_q[0] : 1'b0), "R8 data bit", dout,
                    (m_mode == 4) ? m_q[0] : 1'b0);
      chk(sel == m_sel, "R3 selection", sel, m_sel);
      chk(dac == exp_dac[11:0], "R5 trial word", dac, exp_dac);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic acquire(input int first_hi, input int gap_lo);
    if (first_hi > 0) begin
      start = 1; cyc(first_hi); start = 0; cyc(gap_lo);
    end
    start = 1; cyc(ACQ + 2); start = 0; cyc(1);
  endtask

  task automatic convert(input logic [11:0] val, input int nbits);
    for (int i = 11; i > 11 - nbits; i--) begin
      cmp = val[i]; tick = 1; cyc(1); tick = 0; cyc(1);
    end
  endtask

  task automatic read_bits(input int n, output logic [11:0] got);
    got = '0;
    for (int k = 0; k < n; k++) begin
      sclk = 1; cyc(1); got = {got[10:0], dout}; sclk = 0; cyc(1);
    end
  endtask

  initial begin
    logic [11:0] got;
    cyc(3);
    // R1 reset state
    chk(!oe && !trk && !busy && !sel && dac == 0, "R1 reset outputs",
        {oe, trk, busy, sel}, 0);
    rst_n = 1; cyc(2);

    // R2, R11: track then conversion start
    start = 1; cyc(1);
    chk(trk == 1 && oe == 0, "R2 R11 track entered, pin released", {trk, oe}, 2);
    cyc(ACQ + 2); start = 0; cyc(1);
    chk(busy && oe && !dout, "R2 conversion holds pin low", {busy, oe, dout}, 6);
    // R10: serial clock while converting
    sclk = 1; cyc(1); sclk = 0; cyc(1);
    chk(oe && !dout && busy, "R10 sclk ignored in conversion", {oe, dout}, 2);
    convert(12'hA5C, 12);
    chk(!busy && oe && dout == 1'b1, "R6 MSB presented", {busy, oe, dout}, 3);
    read_bits(12, got);
    chk(got == 12'hA5C && sel == 0, "R7 unipolar result", got, 12'hA5C);
    chk(!oe && !trk && !busy, "R8 released after 12 bits", {oe, trk, busy}, 0);

    // R10: serial clock while idle
    sclk = 1; cyc(2); sclk = 0; cyc(2);
    chk(!oe, "R10 sclk ignored in idle", oe, 0);

    // R3: high-low-high pattern at exact minimum widths
    acquire(PMIN, PMIN);
    chk(sel == 1, "R3 pattern selects alternate", sel, 1);
    convert(12'h123, 12);
    read_bits(12, got);
    chk(got == 12'h923, "R7 bipolar MSB inverted", got, 12'h923);

    // R4: high one sample too short is ignored
    start = 1; cyc(PMIN - 1); start = 0; cyc(3);
    chk(!trk && !busy && !oe, "R4 short high ignored", {trk, busy, oe}, 0);

    // R4: low gap too short cancels pattern
    acquire(4, PMIN - 1);
    chk(sel == 0, "R4 short low cancels alternate", sel, 0);
    convert(12'hFFF, 12);
    read_bits(12, got);
    chk(got == 12'hFFF, "R7 unipolar full scale", got, 12'hFFF);

    // R5: trial word mid-search, then finish
    acquire(0, 0);
    convert(12'hA00, 3);
    chk(dac == 12'hB00, "R5 trial word after three steps", dac, 12'hB00);
    tick = 1; cmp = 0; cyc(1); tick = 0; cyc(5);
    chk(busy && dac == 12'hA80, "R5 no step without tick", dac, 12'hA80);
    convert(12'h000, 8);
    read_bits(12, got);
    chk(got == 12'hA00, "R5 search result", got, 12'hA00);

    // R9: readout stopped early forces alternate once
    acquire(0, 0);
    convert(12'h7FF, 12);
    read_bits(5, got);
    start = 1; cyc(1);
    chk(!oe && trk, "R9 early rise releases pin", {oe, trk}, 1);
    cyc(ACQ + 2); start = 0; cyc(1);
    chk(sel == 1, "R9 forced alternate after short read", sel, 1);
    convert(12'h000, 12);
    read_bits(12, got);
    chk(got == 12'h800, "R9 R7 forced bipolar zero", got, 12'h800);
    acquire(0, 0);
    chk(sel == 0, "R9 force consumed", sel, 0);
    convert(12'h001, 12);
    read_bits(12, got);
    chk(got == 12'h001, "R7 unipolar LSB", got, 12'h001);

    // R9: abort in the middle of a conversion
    acquire(0, 0);
    convert(12'hFFF, 5);
    start = 1; cyc(1);
    chk(!busy && !oe && trk, "R9 abort during conversion", {busy, oe, trk}, 1);
    cyc(ACQ + 2); start = 0; cyc(1);
    chk(sel == 1, "R9 alternate after aborted conversion", sel, 1);
    convert(12'h800, 12);
    read_bits(12, got);
    chk(got == 12'h000, "R7 bipolar mid code", got, 12'h000);

    cyc(4);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule